// File: doc/BRIEF.md
# Coprocessor Address Translator with Wait-State Generation

This block sits between a small coprocessor and the system interconnect. It takes one request at a time (a valid strobe, a 32-bit coprocessor address and a write flag) and decodes the address into one of five windows. Each window has its own translation rule: some windows move up by 0x40000, one moves down by 0x40000, and two pass through unchanged. The block drives the translated system address and a region index. It then counts the wait cycles that belong to that region and pulses a ready strobe when the count runs out.

Two kinds of request never reach the system side:
- An address that falls outside every window, including the reserved hole above the vector window, gives a decode error.
- A write into the exception-vector window that does not hit the single writable word of its 256-byte block is dropped and flagged as a protection violation.

The controller is a four-state machine:
- `ST_IDLE`: accepts a request.
- `ST_BUSY`: the access is in flight and the counter runs down.
- `ST_FAULT`: reports a decode error.
- `ST_DENY`: reports a blocked write.

It has these transitions:
- IDLE→BUSY on a mapped, permitted request.
- IDLE→FAULT on an unmapped address.
- IDLE→DENY on a forbidden vector write.
- BUSY→IDLE when the counter reaches zero.
- FAULT→IDLE and DENY→IDLE unconditionally after one cycle.

Top module: `cop_addr_xlat`

## Requirements
- R1: Addresses 0x0000_0000–0x0000_1FFF (vector window) translate to address+0x40000 with region index 0, and a read there gives ready in the 3rd cycle after the accepting clock edge.
- R2: Addresses 0x0000_4000–0x0001_3FFF translate to address+0x40000 with region index 1, and a read gives ready in exactly the 3rd cycle after the accepting edge.
- R3: Addresses 0x0002_0000–0x0002_FFFF pass through unchanged with region index 2, and a read gives ready in cycle LAT_SHARED.
- R4: Addresses 0x0004_0000–0x0004_7FFF translate to address−0x40000 with region index 3, and a read gives ready in cycle LAT_SHARED.
- R5: Addresses 0x4000_0000–0xBFFF_FFFF pass through unchanged with region index 4, and a read gives ready in cycle LAT_DRAM.
- R6: Any other address, including the reserved 0x2000–0x3FFF hole, raises dec_err in the 1st cycle after acceptance, reports region index 7, and never raises sys_valid or ready.
- R7: In the vector window, a write is permitted only when address bits [7:2] are all zero. Any other vector write raises prot_viol in the 1st cycle, never raises sys_valid or ready, and starts no access.
- R8: A permitted write to any mapped window gives ready in the 1st cycle after acceptance, whatever the region's read latency.
- R9: ready, dec_err and prot_viol are single-cycle pulses and at most one of them is high in any cycle.
- R10: sys_valid is high from the cycle after acceptance up to and including the ready cycle, and sys_addr and region stay stable while it is high. req_valid is ignored while a request is outstanding.
- R11: After reset all strobes are low, sys_addr is 0 and region index is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_addr | input | 32 | Coprocessor address |
| req_write | input | 1 | 1 = write, 0 = read |
| sys_addr | output | 32 | Translated system address |
| sys_valid | output | 1 | System access in flight |
| region | output | 3 | Window index 0–4, 7 = none |
| ready | output | 1 | Access complete pulse |
| dec_err | output | 1 | Unmapped-address pulse |
| prot_viol | output | 1 | Blocked vector-write pulse |

## Verification
The bench builds the block with LAT_SHARED = 4 and LAT_DRAM = 6, instead of the defaults of 13 and 53. These distinct short latencies keep each transaction short. That allows every word of the first 512 bytes of the vector window to be written and read. It also allows a 4 KiB-step sweep over the low 0x60000 bytes and probes at every window edge. Because the three latencies (3, 4 and 6) all differ, a request routed to the wrong region shows up as a ready pulse in the wrong cycle as well as a wrong region index.

// File: rtl/cax_pkg.sv
package cax_pkg;

    typedef enum logic [2:0] {
        RG_VEC  = 3'd0,
        RG_FAST = 3'd1,
        RG_SRB  = 3'd2,
        RG_SRA  = 3'd3,
        RG_DRAM = 3'd4,
        RG_NONE = 3'd7
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_FAULT = 2'd2,
        ST_DENY  = 2'd3
    } state_e;

    localparam int FAST_LAT = 3;
    localparam logic [31:0] SHIFT = 32'h0004_0000;

endpackage

// File: rtl/cax_decode.sv
module cax_decode
    import cax_pkg::*;
(
    input  logic [31:0] addr,
    output region_e     rgn,
    output logic [31:0] xaddr,
    output logic        vec_wr_ok
);
    always_comb begin
        rgn   = RG_NONE;
        xaddr = addr;
        if (addr < 32'h0000_2000) begin
            rgn   = RG_VEC;
            xaddr = addr + SHIFT;
        end else if (addr >= 32'h0000_4000 && addr < 32'h0001_4000) begin
            rgn   = RG_FAST;
            xaddr = addr + SHIFT;
        end else if (addr[31:16] == 16'h0002) begin
            rgn   = RG_SRB;
        end else if (addr[31:15] == 17'h0_0008) begin
            rgn   = RG_SRA;
            xaddr = addr - SHIFT;
        end else if (addr[31:30] == 2'b01 || addr[31:30] == 2'b10) begin
            rgn   = RG_DRAM;
        end
    end

    assign vec_wr_ok = (addr[7:2] == 6'd0);
endmodule

// File: rtl/cax_lat_sel.sv
module cax_lat_sel
    import cax_pkg::*;
#(
    parameter int LAT_SHARED = 13,
    parameter int LAT_DRAM   = 53,
    parameter int CW         = 6
) (
    input  region_e         rgn,
    input  logic            write,
    output logic [CW-1:0]   load
);
    always_comb begin
        if (write) begin
            load = '0;
        end else begin
            unique case (rgn)
                RG_VEC, RG_FAST: load = CW'(FAST_LAT - 1);
                RG_SRB, RG_SRA:  load = CW'(LAT_SHARED - 1);
                RG_DRAM:         load = CW'(LAT_DRAM - 1);
                default:         load = '0;
            endcase
        end
    end
endmodule

// File: rtl/cop_addr_xlat.sv
module cop_addr_xlat
    import cax_pkg::*;
#(
    parameter int LAT_SHARED = 13,
    parameter int LAT_DRAM   = 53
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    input  logic        req_write,
    output logic [31:0] sys_addr,
    output logic        sys_valid,
    output logic [2:0]  region,
    output logic        ready,
    output logic        dec_err,
    output logic        prot_viol
);
    localparam int LMAX0 = (LAT_SHARED > LAT_DRAM) ? LAT_SHARED : LAT_DRAM;
    localparam int LMAX  = (LMAX0 > FAST_LAT) ? LMAX0 : FAST_LAT;
    localparam int CW    = $clog2(LMAX + 1);

    state_e        state;
    logic [CW-1:0] cnt;
    logic [31:0]   xaddr_d;
    region_e       rgn_d;
    region_e       rgn_q;
    logic          vec_ok_d;
    logic [CW-1:0] load_d;

    cax_decode u_dec (
        .addr      (req_addr),
        .rgn       (rgn_d),
        .xaddr     (xaddr_d),
        .vec_wr_ok (vec_ok_d)
    );

    cax_lat_sel #(
        .LAT_SHARED (LAT_SHARED),
        .LAT_DRAM   (LAT_DRAM),
        .CW         (CW)
    ) u_lat (
        .rgn   (rgn_d),
        .write (req_write),
        .load  (load_d)
    );

    // State register, counter and captured address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            sys_addr <= '0;
            rgn_q    <= RG_NONE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        rgn_q <= rgn_d;
                        if (rgn_d == RG_NONE) begin
                            state <= ST_FAULT;
                        end else if (req_write && rgn_d == RG_VEC && !vec_ok_d) begin
                            state <= ST_DENY;
                        end else begin
                            state    <= ST_BUSY;
                            cnt      <= load_d;
                            sys_addr <= xaddr_d;
                        end
                    end
                end
                ST_BUSY: begin
                    if (cnt == '0) state <= ST_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_FAULT: state <= ST_IDLE;
                ST_DENY:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Outputs from state
    always_comb begin
        sys_valid = 1'b0;
        ready     = 1'b0;
        dec_err   = 1'b0;
        prot_viol = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_BUSY: begin
                sys_valid = 1'b1;
                ready     = (cnt == '0);
            end
            ST_FAULT: dec_err   = 1'b1;
            ST_DENY:  prot_viol = 1'b1;
            default:  ;
        endcase
    end

    assign region = rgn_q;
endmodule

// File: rtl/cax_chk.sv
module cax_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] sys_addr,
    input logic        sys_valid,
    input logic [2:0]  region,
    input logic        ready,
    input logic        dec_err,
    input logic        prot_viol
);
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ready, dec_err, prot_viol}));

    a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_err || prot_viol) |=> !(dec_err || prot_viol));

    a_r6_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |-> (!sys_valid && region == 3'd7));

    a_r7_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        prot_viol |-> !sys_valid);

    a_r10_ready_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> sys_valid);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_valid && !ready) |=> (sys_valid && $stable(sys_addr) && $stable(region)));

    a_r1_vec_target: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_valid && region == 3'd0) |-> (sys_addr[31:13] == 19'h00020));

    a_r5_dram_target: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_valid && region == 3'd4) |-> (sys_addr[31:30] == 2'b01 || sys_addr[31:30] == 2'b10));
endmodule

bind cop_addr_xlat cax_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_addr  (sys_addr),
    .sys_valid (sys_valid),
    .region    (region),
    .ready     (ready),
    .dec_err   (dec_err),
    .prot_viol (prot_viol)
);

// File: tb/sim_cop_addr_xlat.sv
module sim_cop_addr_xlat;
    localparam int LS = 4;
    localparam int LD = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] sys_addr;
    logic        sys_valid;
    logic [2:0]  region;
    logic        ready, dec_err, prot_viol;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    cop_addr_xlat #(.LAT_SHARED(LS), .LAT_DRAM(LD)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .sys_addr(sys_addr), .sys_valid(sys_valid),
        .region(region), .ready(ready), .dec_err(dec_err), .prot_viol(prot_viol)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Spec model: kind 0 = ready, 1 = dec_err, 2 = prot_viol
    task automatic model(input logic [31:0] a, input logic wr,
                         output logic [2:0] rg, output logic [31:0] xa,
                         output int kind, output int lat, output string tag);
        rg = 3'd7; xa = a; kind = 1; lat = 1; tag = "R6";
        if (a <= 32'h1FFF) begin
            rg = 0; xa = a + 32'h40000; kind = 0; lat = 3; tag = "R1";
            if (wr && a[7:2] != 0) begin kind = 2; lat = 1; tag = "R7"; end
        end else if (a >= 32'h4000 && a <= 32'h13FFF) begin
            rg = 1; xa = a + 32'h40000; kind = 0; lat = 3; tag = "R2";
        end else if (a >= 32'h20000 && a <= 32'h2FFFF) begin
            rg = 2; kind = 0; lat = LS; tag = "R3";
        end else if (a >= 32'h40000 && a <= 32'h47FFF) begin
            rg = 3; xa = a - 32'h40000; kind = 0; lat = LS; tag = "R4";
        end else if (a >= 32'h40000000 && a <= 32'hBFFFFFFF) begin
            rg = 4; kind = 0; lat = LD; tag = "R5";
        end
        if (wr && kind == 0) begin lat = 1; tag = {tag, "/R8"}; end
    endtask

    task automatic run(input logic [31:0] a, input logic wr, input bit junk);
        logic [2:0] rg; logic [31:0] xa; int kind, lat; string tag;
        int got_n = 0; int got_k = -1;
        model(a, wr, rg, xa, kind, lat, tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr;
        for (int n = 1; n <= 80 && got_n == 0; n++) begin
            @(negedge clk);
            if (junk) begin req_addr = 32'h2_0040; req_write = 1'b0; end
            else req_valid = 1'b0;
            if (n == 1) begin
                chk({tag, " region"}, 64'(region), 64'(rg));
                if (kind == 0) chk({tag, " sys_addr"}, 64'(sys_addr), 64'(xa));
            end
            if (kind == 0) chk("R10 sys_valid in access", 64'(sys_valid), 64'd1);
            else           chk("R6/R7 no access", 64'(sys_valid), 64'd0);
            if (ready || dec_err || prot_viol) begin
                got_n = n;
                got_k = ready ? 0 : (dec_err ? 1 : 2);
                chk("R9 single strobe", 64'(ready + dec_err + prot_viol), 64'd1);
                req_valid = 1'b0;
            end
        end
        chk({tag, " kind"}, 64'(got_k), 64'(kind));
        chk({tag, " latency"}, 64'(got_n), 64'(lat));
        @(negedge clk);
        chk("R9 pulse ends", 64'({ready, dec_err, prot_viol, sys_valid}), 64'd0);
        if (junk) chk("R10 junk ignored", 64'(region), 64'(rg));
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset values
        chk("R11 strobes", 64'({sys_valid, ready, dec_err, prot_viol}), 64'd0);
        chk("R11 region", 64'(region), 64'd7);
        chk("R11 sys_addr", 64'(sys_addr), 64'd0);
        rst_n = 1'b1;

        // R1/R7: every vector word in the first 512 bytes, write then read
        for (int a = 0; a < 32'h200; a += 4) begin
            run(32'(a), 1'b1, 1'b0);
            run(32'(a), 1'b0, 1'b0);
        end
        // Coarse sweep over the low address space (R1-style model for all windows)
        for (int a = 0; a < 32'h60000; a += 32'h1000) begin
            run(32'(a), 1'b0, 1'b0);
            run(32'(a + 32'hFFC), 1'b1, 1'b0);
        end
        // Window edges: R2 R3 R4 R5 R6
        run(32'h0000_1FFC, 1'b0, 1'b0);
        run(32'h0000_1F00, 1'b1, 1'b0);
        run(32'h0000_1F04, 1'b1, 1'b0);
        run(32'h0000_2000, 1'b0, 1'b0);
        run(32'h0000_3FFC, 1'b1, 1'b0);
        run(32'h0000_4000, 1'b0, 1'b0);
        run(32'h0001_3FFC, 1'b0, 1'b0);
        run(32'h0001_4000, 1'b0, 1'b0);
        run(32'h0001_FFFC, 1'b0, 1'b0);
        run(32'h0002_0000, 1'b0, 1'b0);
        run(32'h0002_FFFC, 1'b0, 1'b0);
        run(32'h0003_0000, 1'b0, 1'b0);
        run(32'h0004_0000, 1'b0, 1'b0);
        run(32'h0004_7FFC, 1'b0, 1'b0);
        run(32'h0004_8000, 1'b0, 1'b0);
        run(32'h3FFF_FFFC, 1'b0, 1'b0);
        run(32'h4000_0000, 1'b0, 1'b0);
        run(32'h8123_4568, 1'b1, 1'b0);
        run(32'hBFFF_FFFC, 1'b0, 1'b0);
        run(32'hC000_0000, 1'b0, 1'b0);
        run(32'hFFFF_FFFC, 1'b1, 1'b0);
        // R10: req_valid held high with another address during long accesses
        run(32'h4000_1000, 1'b0, 1'b1);
        run(32'h0004_0100, 1'b0, 1'b1);
        run(32'h0000_5000, 1'b0, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule